// File: doc/BRIEF.md
# Transmit Timestamp Capture and Extender

This block keeps the departure time of the most recent transmitted frame on one port. A departure strobe copies the low `TS_BITS` bits of a free-running 64-bit time counter into a holding register and raises a ready flag. The host reads the flag and the stored value through two 32-bit readout words, then drops the flag with an acknowledge pulse. `TS_BITS` is 24 or 32, and the two settings pack the readout words differently.

Some time later the host asks the extender for the full timestamp with a request pulse. The extender joins the upper counter bits to the stored partial value. It corrects for a single wrap of the short field and presents the 64-bit result with a valid pulse one cycle after the request. The result is right only if the request arrives no more than one wrap period (2^TS_BITS counter ticks) after the capture.

Top module: `egress_ts_capture`

## Requirements
- R1: After a synchronous active-low reset, the ready flag is 0, the stored value is 0, both readout words are 0, `full_vld` is 0 and `full_ts` is 0.
- R2: A clock edge with `depart` high stores `time_now[TS_BITS-1:0]` as sampled at that edge and sets the ready flag. The stored value then stays unchanged until the next departure.
- R3: An `ack` pulse without `depart` clears the ready flag and leaves the stored value unchanged.
- R4: A departure while the flag is already set overwrites the stored value and keeps the flag set. When `depart` and `ack` are high at the same edge, the departure wins and the flag stays set.
- R5: With TS_BITS=24, `word0` holds the ready flag at bit 0, zeros in bits 7:1 and the stored value in bits 31:8, and `word1` is all zeros.
- R6: With TS_BITS=32, `word0` holds the ready flag at bit 0 and zeros in bits 31:1, and `word1` holds the whole stored value.
- R7: On a request the extender forms `{time_now[63:TS_BITS], stored}`. It subtracts 2^TS_BITS (modulo 2^64) when `time_now[TS_BITS-1:0]` is less than or equal to the stored value, including the equal case.
- R8: `full_vld` is high exactly in the cycle after an `ext_req` edge and low otherwise. `full_ts` changes only on a request and holds its value in between.
- R9: When the counter has advanced by 1 to 2^TS_BITS ticks between capture and request, including across a wrap of the short field, `full_ts` equals the counter value at capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 64 | Free-running time counter |
| depart | input | 1 | Frame-departure strobe, one cycle |
| ack | input | 1 | Host acknowledge, clears the ready flag |
| word0 | output | 32 | Readout word 0: ready flag at bit 0, plus the timestamp when TS_BITS=24 |
| word1 | output | 32 | Readout word 1: the timestamp when TS_BITS=32, else zero |
| ext_req | input | 1 | Request to rebuild the full timestamp |
| full_ts | output | 64 | Rebuilt 64-bit timestamp |
| full_vld | output | 1 | One-cycle pulse marking a new `full_ts` |

## Verification
The bench builds two copies of the block side by side, one with TS_BITS=24 and one with TS_BITS=32, and drives both from the same stimulus. The 24-bit copy carries the table of capture and request times. Its short wrap period lets the table reach a wrap of the short field, a request exactly one wrap period after capture (the equal-low-bits case), a request one tick past a wrap, a request in the same cycle as the capture, and a counter near the top of its 64-bit range. The 32-bit copy checks the other readout layout and a wrap across a 32-bit boundary.

// File: rtl/egts_pkg.sv
// Shared widths and types for the transmit timestamp capture block.
// Assumes a 64-bit free-running time counter and 32-bit readout words.
package egts_pkg;
    localparam int unsigned FULL_W = 64;
    localparam int unsigned WORD_W = 32;
    typedef logic [FULL_W-1:0] full_ts_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/egts_capture.sv
// Holding register for one port's partial departure time, with its ready flag.
// Assumes depart is a single-cycle strobe. A departure overrides a same-cycle ack.
module egts_capture #(
    parameter int unsigned TS_BITS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               depart,
    input  logic               ack,
    input  logic [TS_BITS-1:0] cnt_low,
    output logic               flag,
    output logic [TS_BITS-1:0] held
);
    // Store the counter bits on a departure; only ack clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            held <= '0;
        end else if (depart) begin
            flag <= 1'b1;
            held <= cnt_low;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/egts_pack.sv
// Packs the flag and the held partial time into two readout words.
// With a short field the value sits at the top of word 0. A full 32-bit field moves to word 1.
// Assumes TS_BITS is 32 or at most 31; the flag always sits at bit 0 of word 0.
module egts_pack
    import egts_pkg::*;
#(
    parameter int unsigned TS_BITS = 24
) (
    input  logic               flag,
    input  logic [TS_BITS-1:0] held,
    output word_t              word0,
    output word_t              word1
);
    localparam int unsigned GAP = (TS_BITS < WORD_W) ? (WORD_W - TS_BITS - 1) : 1;

    generate
        if (TS_BITS == WORD_W) begin : g_two_word
            // Flag alone in word 0, the value fills word 1.
            always_comb begin
                word0 = {{(WORD_W-1){1'b0}}, flag};
                word1 = word_t'(held);
            end
        end else begin : g_one_word
            // Value in the upper bits of word 0, zero gap, then the flag.
            always_comb begin
                word0 = {held, {GAP{1'b0}}, flag};
                word1 = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/egts_extend.sv
// Rebuilds a 64-bit time from the held partial value and the current counter.
// Corrects for at most one wrap of the short field. The sum is combinational and the output is registered.
// Assumes the request comes within 2^TS_BITS ticks of the capture.
module egts_extend
    import egts_pkg::*;
#(
    parameter int unsigned TS_BITS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  full_ts_t           now,
    input  logic [TS_BITS-1:0] part,
    output full_ts_t           full_ts,
    output logic               full_vld
);
    localparam full_ts_t WRAP = full_ts_t'(1) << TS_BITS;

    full_ts_t joined;
    full_ts_t rebuilt;
    logic     wrapped;

    // Join the upper counter bits to the partial value and undo one wrap.
    always_comb begin
        joined  = {now[FULL_W-1:TS_BITS], part};
        wrapped = (now[TS_BITS-1:0] <= part);
        rebuilt = wrapped ? (joined - WRAP) : joined;
    end

    // Register the result on a request; pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_ts  <= '0;
            full_vld <= 1'b0;
        end else begin
            full_vld <= req;
            if (req) full_ts <= rebuilt;
        end
    end
endmodule

// File: rtl/egress_ts_capture.sv
// Top level: one port's transmit timestamp register, its readout words and the full-width extender.
// Assumes TS_BITS is 24 or 32 and time_now is a free-running 64-bit counter.
module egress_ts_capture
    import egts_pkg::*;
#(
    parameter int unsigned TS_BITS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] time_now,
    input  logic        depart,
    input  logic        ack,
    output logic [31:0] word0,
    output logic [31:0] word1,
    input  logic        ext_req,
    output logic [63:0] full_ts,
    output logic        full_vld
);
    logic               cap_flag;
    logic [TS_BITS-1:0] cap_val;

    egts_capture #(.TS_BITS(TS_BITS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .depart  (depart),
        .ack     (ack),
        .cnt_low (time_now[TS_BITS-1:0]),
        .flag    (cap_flag),
        .held    (cap_val)
    );

    egts_pack #(.TS_BITS(TS_BITS)) u_pack (
        .flag  (cap_flag),
        .held  (cap_val),
        .word0 (word0),
        .word1 (word1)
    );

    egts_extend #(.TS_BITS(TS_BITS)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (ext_req),
        .now      (time_now),
        .part     (cap_val),
        .full_ts  (full_ts),
        .full_vld (full_vld)
    );
endmodule

// File: rtl/egts_checker.sv
// Temporal checks for egress_ts_capture, attached with bind below.
module egts_checker #(
    parameter int unsigned TS_BITS = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [63:0]        time_now,
    input logic               depart,
    input logic               ack,
    input logic               ext_req,
    input logic [31:0]        word0,
    input logic [63:0]        full_ts,
    input logic               full_vld,
    input logic               cap_flag,
    input logic [TS_BITS-1:0] cap_val
);
    // R2
    capture_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depart |=> (word0[0] && cap_val == $past(time_now[TS_BITS-1:0])));

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !depart) |=> (!word0[0] && cap_val == $past(cap_val)));

    // R4
    depart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (depart && ack) |=> cap_flag);

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |=> full_vld);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_req |=> (!full_vld && $stable(full_ts)));

    // R7
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |=> (full_ts[TS_BITS-1:0] == $past(cap_val)));
endmodule

bind egress_ts_capture egts_checker #(.TS_BITS(TS_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .time_now (time_now),
    .depart   (depart),
    .ack      (ack),
    .ext_req  (ext_req),
    .word0    (word0),
    .full_ts  (full_ts),
    .full_vld (full_vld),
    .cap_flag (cap_flag),
    .cap_val  (cap_val)
);

// File: tb/sim_egress_ts_capture.sv
`timescale 1ns/1ps
module sim_egress_ts_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        depart = 1'b0;
    logic        ack = 1'b0;
    logic        ext_req = 1'b0;
    logic [31:0] w0_a, w1_a, w0_b, w1_b;
    logic [63:0] fts_a, fts_b;
    logic        fv_a, fv_b;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    egress_ts_capture #(.TS_BITS(24)) u0 (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .depart(depart), .ack(ack),
        .word0(w0_a), .word1(w1_a), .ext_req(ext_req), .full_ts(fts_a), .full_vld(fv_a)
    );

    egress_ts_capture #(.TS_BITS(32)) u1 (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .depart(depart), .ack(ack),
        .word0(w0_b), .word1(w1_b), .ext_req(ext_req), .full_ts(fts_b), .full_vld(fv_b)
    );

    // Each row: capture time, request time, expected rebuilt time (24-bit copy).
    localparam logic [191:0] VEC [0:5] = '{
        {64'h0000_0001_0012_3456, 64'h0000_0001_0012_3556, 64'h0000_0001_0012_3456},
        {64'h0000_0001_00FF_FFF0, 64'h0000_0001_0100_0010, 64'h0000_0001_00FF_FFF0},
        {64'h0000_0000_0500_1234, 64'h0000_0000_0600_1234, 64'h0000_0000_0500_1234},
        {64'h0000_0000_0700_0042, 64'h0000_0000_0700_0042, 64'h0000_0000_0600_0042},
        {64'h0000_0000_0AFF_FFFF, 64'h0000_0000_0B00_0000, 64'h0000_0000_0AFF_FFFF},
        {64'hFFFF_FFFF_FF00_0005, 64'hFFFF_FFFF_FF00_0015, 64'hFFFF_FFFF_FF00_0005}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Capture at time c, then request at time n; result is visible after that.
    task automatic cap_then_req(input logic [63:0] c, input logic [63:0] n);
        time_now = c; depart = 1'b1;
        step();
        depart = 1'b0; time_now = n; ext_req = 1'b1;
        step();
        ext_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] held_ts;
        repeat (3) step();
        // R1 reset state on both copies
        chk("R1 w0_24", w0_a, 0); chk("R1 w1_24", w1_a, 0);
        chk("R1 w0_32", w0_b, 0); chk("R1 w1_32", w1_b, 0);
        chk("R1 vld", fv_a, 0);   chk("R1 ts", fts_a, 0);
        rst_n = 1'b1;
        step();

        // R2 R5 R6 capture and both layouts
        time_now = 64'hAAAA_BBBB_00C0_FFEE; depart = 1'b1;
        step();
        depart = 1'b0; time_now = 64'h1234_5678_9ABC_DEF0;
        chk("R2 R5 w0_24", w0_a, 32'hC0FF_EE01);
        chk("R5 w1_24", w1_a, 0);
        chk("R6 w0_32", w0_b, 32'h0000_0001);
        chk("R6 w1_32", w1_b, 32'h00C0_FFEE);
        step();
        chk("R2 held", w0_a, 32'hC0FF_EE01);

        // R3 ack clears the flag, value stays
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk("R3 w0_24", w0_a, 32'hC0FF_EE00);
        chk("R3 w1_32", w1_b, 32'h00C0_FFEE);
        chk("R3 w0_32", w0_b, 32'h0);

        // R4 overwrite while set, and depart beating ack
        time_now = 64'h0000_0000_0012_3456; depart = 1'b1;
        step();
        time_now = 64'h0000_0000_0034_5678;
        step();
        depart = 1'b0;
        chk("R4 overwrite", w0_a, 32'h3456_7801);
        time_now = 64'h0000_0000_0000_0ABC; depart = 1'b1; ack = 1'b1;
        step();
        depart = 1'b0; ack = 1'b0;
        chk("R4 depart wins 24", w0_a, 32'h000A_BC01);
        chk("R4 depart wins 32", w0_b, 32'h0000_0001);

        // R7 R9 table of capture/request pairs on the 24-bit copy
        for (int i = 0; i < 6; i++) begin
            cap_then_req(VEC[i][191:128], VEC[i][127:64]);
            chk("R7 R9 rebuilt", fts_a, VEC[i][63:0]);
            chk("R8 vld high", fv_a, 1);
            held_ts = fts_a;
            time_now = time_now + 64'd7;
            step();
            chk("R8 vld low", fv_a, 0);
            chk("R8 ts held", fts_a, held_ts);
        end

        // R7 R9 32-bit copy across a 32-bit wrap
        cap_then_req(64'h0000_0012_FFFF_FF00, 64'h0000_0013_0000_0100);
        chk("R7 R9 rebuilt 32", fts_b, 64'h0000_0012_FFFF_FF00);
        chk("R8 vld 32", fv_b, 1);

        // R7 equal low bits on the 32-bit copy subtracts a wrap
        cap_then_req(64'h0000_0005_0000_0010, 64'h0000_0005_0000_0010);
        chk("R7 equal 32", fts_b, 64'h0000_0004_0000_0010);

        // R1 reset again clears outputs
        rst_n = 1'b0;
        step();
        chk("R1 re-reset w0", w0_a, 0);
        chk("R1 re-reset ts", fts_b, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule